// File: doc/BRIEF.md
# Embedded Core Test Wrapper Chain

This block sits around an embedded core and gives a tester serial access to every core terminal. Each core input terminal and each core output terminal has its own wrapper element. An element holds a capture/shift flop and a separate update stage. The flops of all elements form a single serial chain between `scan_in` and `scan_out`. Strobes from outside choose what the chain does on each clock: capture parallel values, shift one position, or copy the chain into the update stages.

A 2-bit wrapper mode register, loaded serially, sets how the elements act. In functional mode both directions pass straight through. In external-test mode the output elements drive the host-side nets from their update stages so that the interconnect can be tested, and the input elements record what arrives from the host. In internal-test mode the input elements drive the core inputs from their update stages, and the output elements record what the core produces. A reset places the block in functional mode.

Top module: `core_wrap_chain`

## Requirements
- R1: While reset is asserted and after it is released, the mode is functional, every chain flop and update stage reads 0, `scan_out` is 0, `core_in` equals `host_in` and `host_out` equals `core_out`.
- R2: In mode code 2'b00 (functional), `core_in` equals `host_in` and `host_out` equals `core_out` on every cycle, whatever the chain is doing.
- R3: In mode code 2'b01 (external test), bit j of `host_out` equals the update stage of output element j, and `core_in` still follows `host_in`.
- R4: In mode code 2'b10 (internal test), bit i of `core_in` equals the update stage of input element i, and `host_out` still follows `core_out`.
- R5: A cycle with `capture_en` high loads input element i from `host_in[i]` and output element j from `core_out[j]`. Capture takes priority when `shift_en` is also high.
- R6: A cycle with `shift_en` high and `capture_en` low moves the chain one place. Data enters input element 0 from `scan_in`, runs through the input elements in rising index, then through the output elements in rising index, and the last output element's flop drives `scan_out`.
- R7: A cycle with `update_en` high copies each chain flop into its update stage. Without `update_en` the update stages, and so every driven test value, do not change during shift or capture.
- R8: On each cycle with `instr_shift` high, `instr_si` enters bit 1 of a 2-bit staging register while the old bit 1 moves to bit 0, so the code goes in LSB first. `instr_update` copies the staging register into the active mode. Until that happens, shifting does not change the mode.
- R9: Mode code 2'b11 behaves exactly like functional mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_in | input | N_IN | Values the host drives toward the core inputs |
| core_in | output | N_IN | Values presented to the core inputs |
| core_out | input | N_OUT | Values produced by the core outputs |
| host_out | output | N_OUT | Values presented to the host side |
| scan_in | input | 1 | Serial data into input element 0 |
| scan_out | output | 1 | Serial data from the last output element |
| shift_en | input | 1 | Shift the chain one place |
| capture_en | input | 1 | Load the chain from the terminals |
| update_en | input | 1 | Copy the chain into the update stages |
| instr_si | input | 1 | Serial mode code bit |
| instr_shift | input | 1 | Shift the mode staging register |
| instr_update | input | 1 | Apply the staged mode code |

## Verification
A wrong chain flop appears at `scan_out` within N_IN+N_OUT shift cycles, and the flop order can be read from when each bit emerges. A wrong update stage shows on `host_out` or `core_in` as soon as the mode lets that element drive. A wrong mode value shows in the same cycle, because either a driven pin stops following its functional source or a test value fails to appear. The reference model is compared with all three output ports on every cycle, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  localparam int WMODE_W = 2;

  typedef enum logic [WMODE_W-1:0] {
    WM_FUNC  = 2'b00,
    WM_EXT   = 2'b01,
    WM_INT   = 2'b10,
    WM_SPARE = 2'b11
  } wmode_e;
endpackage

// File: rtl/cwc_rst_sync.sv
module cwc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) pipe_q <= '0;
    else              pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/cwc_mode_reg.sv
module cwc_mode_reg
  import cwc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shift_en,
  input  logic   si,
  input  logic   update_en,
  output wmode_e mode
);
  logic [WMODE_W-1:0] stage_q, stage_d;
  wmode_e             mode_q, mode_d;

  always_comb begin
    stage_d = {si, stage_q[WMODE_W-1:1]};
    mode_d  = wmode_e'(stage_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      mode_q  <= WM_FUNC;
    end else begin
      if (shift_en)  stage_q <= stage_d;
      if (update_en) mode_q  <= mode_d;
    end
  end

  assign mode = mode_q;

  assert_mode_reset_R1: assert property (@(posedge clk)
    !rst_n |-> mode_q == WM_FUNC);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(mode_q));

  assert_mode_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> mode_q == wmode_e'($past(stage_q)));
endmodule

// File: rtl/cwc_cell.sv
module cwc_cell
  import cwc_pkg::*;
#(
  parameter bit DIR_IN = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  wmode_e mode,
  input  logic   thru,
  input  logic   si,
  input  logic   shift_en,
  input  logic   capture_en,
  input  logic   update_en,
  output logic   so,
  output logic   drive
);
  logic sr_q, sr_d, sr_en;
  logic upd_q;
  logic ovr;

  generate
    if (DIR_IN) begin : g_in_side
      assign ovr = (mode == WM_INT);
    end else begin : g_out_side
      assign ovr = (mode == WM_EXT);
    end
  endgenerate

  always_comb begin
    sr_en = capture_en | shift_en;
    sr_d  = capture_en ? thru : si;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (sr_en)     sr_q  <= sr_d;
      if (update_en) upd_q <= sr_q;
    end
  end

  assign so    = sr_q;
  assign drive = ovr ? upd_q : thru;

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> sr_q == $past(thru));

  assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture_en) |=> sr_q == $past(si));

  assert_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> upd_q == $past(sr_q));

  assert_upd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(upd_q));
endmodule

// File: rtl/core_wrap_chain.sv
module core_wrap_chain
  import cwc_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  host_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] host_out,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en,
  input  logic             instr_si,
  input  logic             instr_shift,
  input  logic             instr_update
);
  localparam int N_CELLS = N_IN + N_OUT;

  logic           rst_sync_n;
  wmode_e         mode;
  logic [N_CELLS:0] link;

  cwc_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  cwc_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_en  (instr_shift),
    .si        (instr_si),
    .update_en (instr_update),
    .mode      (mode)
  );

  assign link[0] = scan_in;

  generate
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
      cwc_cell #(.DIR_IN(1'b1)) u_cell (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .mode       (mode),
        .thru       (host_in[gi]),
        .si         (link[gi]),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .so         (link[gi+1]),
        .drive      (core_in[gi])
      );
    end
    for (genvar go = 0; go < N_OUT; go++) begin : g_out
      cwc_cell #(.DIR_IN(1'b0)) u_cell (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .mode       (mode),
        .thru       (core_out[go]),
        .si         (link[N_IN+go]),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .so         (link[N_IN+go+1]),
        .drive      (host_out[go])
      );
    end
  endgenerate

  assign scan_out = link[N_CELLS];

  assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == WM_FUNC || mode == WM_SPARE) |-> (core_in == host_in && host_out == core_out));

  assert_ext_inputs_pass_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == WM_EXT) |-> core_in == host_in);

  assert_int_outputs_pass_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == WM_INT) |-> host_out == core_out);

  assert_scan_shift_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && !capture_en) |=> scan_out == $past(link[N_CELLS-1]));
endmodule

// File: tb/test_core_wrap_chain.sv
`timescale 1ns/1ps
module test_core_wrap_chain;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int NT = NI + NO;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] host_in;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out;
  logic [NO-1:0] host_out;
  logic          scan_in, scan_out;
  logic          shift_en, capture_en, update_en;
  logic          instr_si, instr_shift, instr_update;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  core_wrap_chain #(.N_IN(NI), .N_OUT(NO)) i_core_wrap_chain (
    .clk(clk), .rst_n(rst_n), .host_in(host_in), .core_in(core_in),
    .core_out(core_out), .host_out(host_out), .scan_in(scan_in),
    .scan_out(scan_out), .shift_en(shift_en), .capture_en(capture_en),
    .update_en(update_en), .instr_si(instr_si), .instr_shift(instr_shift),
    .instr_update(instr_update)
  );

  // Behavioural reference: chain as a queue-like array, index 0 next to scan_in.
  bit       m_chain [NT];
  bit       m_upd   [NT];
  bit [1:0] m_stage;
  bit [1:0] m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) begin m_chain[k] = 0; m_upd[k] = 0; end
      m_stage = 0;
      m_mode  = 0;
    end else begin
      if (update_en) for (int k = 0; k < NT; k++) m_upd[k] = m_chain[k];
      if (capture_en) begin
        for (int k = 0; k < NI; k++) m_chain[k] = host_in[k];
        for (int k = 0; k < NO; k++) m_chain[NI+k] = core_out[k];
      end else if (shift_en) begin
        for (int k = NT-1; k > 0; k--) m_chain[k] = m_chain[k-1];
        m_chain[0] = scan_in;
      end
      if (instr_update) m_mode = m_stage;
      if (instr_shift)  m_stage = {instr_si, m_stage[1]};
    end
  end

  function automatic logic [NI-1:0] exp_core_in();
    logic [NI-1:0] v;
    for (int k = 0; k < NI; k++) v[k] = (m_mode == 2'b10) ? m_upd[k] : host_in[k];
    return v;
  endfunction

  function automatic logic [NO-1:0] exp_host_out();
    logic [NO-1:0] v;
    for (int k = 0; k < NO; k++) v[k] = (m_mode == 2'b01) ? m_upd[NI+k] : core_out[k];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) at %0t: actual %h expected %h", tag, phase, $time, got, exp);
    end
  endtask

  // Per-cycle comparison of all outputs against the model.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk("R6 scan_out", 32'(scan_out), 32'(m_chain[NT-1]));
      chk((m_mode == 2'b10) ? "R4 core_in" : "R2 core_in", 32'(core_in), 32'(exp_core_in()));
      chk((m_mode == 2'b01) ? "R3 host_out" : "R2 host_out", 32'(host_out), 32'(exp_host_out()));
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic idle(int n); for (int k = 0; k < n; k++) tick(); endtask

  task automatic load_mode(logic [1:0] m);
    instr_shift = 1; instr_si = m[0]; tick();
    instr_si = m[1]; tick();
    instr_shift = 0; instr_update = 1; tick();
    instr_update = 0;
  endtask

  task automatic shift_word(logic [NT-1:0] w);
    shift_en = 1;
    for (int k = 0; k < NT; k++) begin scan_in = w[k]; tick(); end
    shift_en = 0;
  endtask

  task automatic pulse_update(); update_en = 1; tick(); update_en = 0; endtask

  task automatic do_reset();
    shift_en = 0; capture_en = 0; update_en = 0;
    instr_shift = 0; instr_update = 0; instr_si = 0; scan_in = 0;
    rst_n = 0; idle(3);
    rst_n = 1; idle(4);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 50000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected under 50000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    host_in = 4'hA; core_out = 4'h5;
    do_reset();

    phase = "R1";
    @(negedge clk); #1;
    chk("R1 scan_out after reset", 32'(scan_out), 32'h0);
    chk("R1 core_in after reset", 32'(core_in), 32'hA);
    chk("R1 host_out after reset", 32'(host_out), 32'h5);
    tick();

    phase = "R2";
    for (int k = 0; k < 12; k++) begin
      host_in = 4'($urandom); core_out = 4'($urandom);
      shift_en = 1; scan_in = 1'($urandom); tick();
    end
    shift_en = 0;
    pulse_update();
    chk("R2 core_in transparent after update", 32'(core_in), 32'(host_in));

    phase = "R6";
    shift_word(8'b1011_0010);
    shift_word(8'b0110_1101);

    phase = "R8";
    instr_shift = 1; instr_si = 1; tick();
    instr_si = 0; tick(); instr_shift = 0;
    @(negedge clk); #1;
    chk("R8 host_out unchanged while mode only staged", 32'(host_out), 32'(core_out));
    tick();
    instr_update = 1; tick(); instr_update = 0;

    phase = "R3";
    core_out = 4'h3; host_in = 4'hC;
    shift_word(8'b1100_1010);
    pulse_update();
    @(negedge clk); #1;
    chk("R3 host_out from update stages", 32'(host_out), 32'(exp_host_out()));
    chk("R3 core_in follows host_in", 32'(core_in), 32'hC);
    tick();

    phase = "R7";
    shift_word(8'b0011_0101);
    capture_en = 1; tick(); capture_en = 0;
    @(negedge clk); #1;
    chk("R7 host_out held without update", 32'(host_out), 32'(exp_host_out()));
    tick();
    pulse_update();

    phase = "R4";
    load_mode(2'b10);
    shift_word(8'b1001_0110);
    pulse_update();
    core_out = 4'h9; host_in = 4'h6;
    @(negedge clk); #1;
    chk("R4 core_in from update stages", 32'(core_in), 32'(exp_core_in()));
    chk("R4 host_out follows core_out", 32'(host_out), 32'h9);
    tick();

    phase = "R5";
    host_in = 4'b1101; core_out = 4'b0110;
    capture_en = 1; shift_en = 1; scan_in = 1; tick();
    capture_en = 0; shift_en = 0;
    @(negedge clk); #1;
    chk("R5 capture wins, scan_out = core_out[3]", 32'(scan_out), 32'h0);
    tick();
    shift_en = 1; scan_in = 0;
    for (int k = 0; k < NT; k++) tick();
    shift_en = 0;

    phase = "R9";
    load_mode(2'b11);
    shift_word(8'hFF);
    pulse_update();
    host_in = 4'h1; core_out = 4'h8;
    @(negedge clk); #1;
    chk("R9 code 11 core_in transparent", 32'(core_in), 32'h1);
    chk("R9 code 11 host_out transparent", 32'(host_out), 32'h8);
    tick();

    phase = "mixed";
    for (int k = 0; k < 400; k++) begin
      host_in = 4'($urandom); core_out = 4'($urandom);
      scan_in = 1'($urandom); shift_en = 1'($urandom);
      capture_en = ($urandom % 5) == 0; update_en = ($urandom % 4) == 0;
      instr_si = 1'($urandom); instr_shift = 1'($urandom);
      instr_update = ($urandom % 6) == 0;
      tick();
    end

    phase = "R1";
    do_reset();
    host_in = 4'h7; core_out = 4'hE;
    @(negedge clk); #1;
    chk("R1 scan_out after second reset", 32'(scan_out), 32'h0);
    chk("R1 host_out transparent after second reset", 32'(host_out), 32'hE);
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule